// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. A fresh 18-bit start address is captured on a clock edge when one of two active-low address strobes is asserted. The first strobe always loads. The second strobe loads only while the active-low chip enable is asserted. After a load, an active-low advance input steps an internal two-bit beat counter. The two lowest address bits follow the start value combined with that counter. The upper address bits keep their captured value, so each burst is four beats long and wraps.

A static order-select input chooses how the beat counter combines with the start bits. Low selects linear order: the start value plus the count, modulo four. High selects interleaved order: the start value XOR the count. A sleep input stops the internal clock enable, so all state freezes while it is high. A one-bit load flag shows that the current address came from a capture on the last active edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is 0 and `load_seen` is 0, independent of the clock.
- R2: If `sa_ctl_n` is low at an active edge, `addr_out` becomes `addr_in` after that edge and `load_seen` becomes 1. The state of `chip_en_n` does not matter.
- R3: If `sa_cpu_n` and `chip_en_n` are both low at an active edge, `addr_out` becomes `addr_in` and `load_seen` becomes 1.
- R4: If `sa_cpu_n` is low while `chip_en_n` is high, and `sa_ctl_n` is high, the edge does not load. `addr_out` then follows only the advance rule, and `load_seen` is 0.
- R5: At an edge with no load, `adv_n` low steps the beat count by one, modulo 4. `adv_n` high holds `addr_out`.
- R6: With `burst_order` = 0 (linear), `addr_out[1:0]` equals (captured start bits + beat count) mod 4.
- R7: With `burst_order` = 1 (interleaved), `addr_out[1:0]` equals the captured start bits XOR the beat count.
- R8: Between loads, `addr_out[17:2]` keeps the value captured at the last load.
- R9: A load clears the beat count to 0 and wins over `adv_n` low in the same edge.
- R10: While `sleep` is high at an edge, `addr_out` and `load_seen` keep their values, and strobes, advance and address are ignored.
- R11: After each active edge (`sleep` low), `load_seen` is 1 exactly when that edge performed a load. Back-to-back loads keep it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 18 | External start address |
| sa_ctl_n | input | 1 | Ungated address strobe, active low |
| sa_cpu_n | input | 1 | Address strobe gated by chip enable, active low |
| chip_en_n | input | 1 | Chip enable qualifying `sa_cpu_n`, active low |
| adv_n | input | 1 | Burst advance request, active low |
| burst_order | input | 1 | 0 = linear, 1 = interleaved; static |
| sleep | input | 1 | High freezes all state |
| addr_out | output | 18 | Current word address |
| load_seen | output | 1 | Last active edge captured a new address |

## Verification
A load and an advance can be requested in the same edge. The bench provokes this by driving a strobe together with `adv_n` low, once through the gated strobe and once through the ungated strobe while chip enable is deasserted. It judges the result by the low address bits: they must equal the new start address exactly, with no step applied. A sleep edge that carries both a strobe and an advance must disturb neither the address nor the load flag.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int BAS_ADDR_W  = 18;
  localparam int BAS_BURST_W = 2;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bas_load_ctrl.sv
module bas_load_ctrl (
  input  logic sa_ctl_n,
  input  logic sa_cpu_n,
  input  logic chip_en_n,
  output logic load
);
  logic ctl_req;
  logic cpu_req;

  always_comb begin
    ctl_req = ~sa_ctl_n;
    cpu_req = ~sa_cpu_n & ~chip_en_n;
    load    = ctl_req | cpu_req;
  end
endmodule

// File: rtl/bas_burst_cnt.sv
module bas_burst_cnt #(
  parameter int BURST_W = bas_pkg::BAS_BURST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic               load,
  input  logic               adv,
  output logic [BURST_W-1:0] cnt
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clk_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load) |=> (cnt_q == '0));

  // R5
  adv_steps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load && adv) |=> (cnt_q == BURST_W'($past(cnt_q) + ONE)));

  // R10
  sleep_holds_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en) |=> $stable(cnt_q));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map #(
  parameter int BURST_W = bas_pkg::BAS_BURST_W
) (
  input  logic               [BURST_W-1:0] start,
  input  logic               [BURST_W-1:0] cnt,
  input  bas_pkg::burst_order_e             order,
  output logic               [BURST_W-1:0] low_bits
);
  logic [BURST_W-1:0] lin_bits;
  logic [BURST_W-1:0] ilv_bits;

  always_comb begin
    lin_bits = start + cnt;
    ilv_bits = start ^ cnt;
    case (order)
      bas_pkg::ORDER_INTERLEAVED: low_bits = ilv_bits;
      default:                    low_bits = lin_bits;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W  = bas_pkg::BAS_ADDR_W,
  parameter int BURST_W = bas_pkg::BAS_BURST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sa_ctl_n,
  input  logic              sa_cpu_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              burst_order,
  input  logic              sleep,
  output logic [ADDR_W-1:0] addr_out,
  output logic              load_seen
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic                load;
  logic                clk_en;
  logic [BURST_W-1:0]  cnt;
  logic [BURST_W-1:0]  low_bits;
  logic [ADDR_W-1:0]   base_q;
  logic [ADDR_W-1:0]   base_d;
  logic                seen_q;
  logic                seen_d;

  assign clk_en = ~sleep;

  bas_load_ctrl u_load_ctrl (
    .sa_ctl_n  (sa_ctl_n),
    .sa_cpu_n  (sa_cpu_n),
    .chip_en_n (chip_en_n),
    .load      (load)
  );

  bas_burst_cnt #(.BURST_W(BURST_W)) u_burst_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .load   (load),
    .adv    (~adv_n),
    .cnt    (cnt)
  );

  bas_order_map #(.BURST_W(BURST_W)) u_order_map (
    .start    (base_q[BURST_W-1:0]),
    .cnt      (cnt),
    .order    (bas_pkg::burst_order_e'(burst_order)),
    .low_bits (low_bits)
  );

  always_comb begin
    base_d = load ? addr_in : base_q;
    seen_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      seen_q <= 1'b0;
    end else if (clk_en) begin
      base_q <= base_d;
      seen_q <= seen_d;
    end
  end

  assign addr_out  = {base_q[ADDR_W-1:BURST_W], low_bits};
  assign load_seen = seen_q;

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_out[ADDR_W-1:BURST_W]));

  // R11
  load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (load_seen == $past(load)));

  // R10
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(addr_out) && $stable(load_seen)));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sa_ctl_n) |=> (addr_out == $past(addr_in)));

  initial begin
    assert (UPPER_W > 0) else $error("address narrower than burst field");
  end
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] addr_in;
  logic        sa_ctl_n, sa_cpu_n, chip_en_n, adv_n, burst_order, sleep;
  logic [17:0] addr_out;
  logic        load_seen;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .sa_ctl_n(sa_ctl_n),
    .sa_cpu_n(sa_cpu_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .burst_order(burst_order), .sleep(sleep),
    .addr_out(addr_out), .load_seen(load_seen)
  );

  typedef struct packed {
    logic        ctl_n;
    logic        cpu_n;
    logic        ce_n;
    logic        adv_n;
    logic        slp;
    logic [17:0] din;
    logic [17:0] exp_a;
    logic        exp_ld;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  // linear order throughout; req holds the requirement number
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,1'b0,18'h2A5F6,18'h2A5F6,1'b1,4'd2},  // R2 load
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h2A5F7,1'b0,4'd6},  // R6 2+1
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h2A5F4,1'b0,4'd6},  // R6 wrap, R8
    '{1'b1,1'b1,1'b1,1'b1,1'b0,18'h00000,18'h2A5F4,1'b0,4'd5},  // R5 hold
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h2A5F5,1'b0,4'd6},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h2A5F6,1'b0,4'd5},  // R5 count wraps
    '{1'b1,1'b0,1'b1,1'b1,1'b0,18'h10003,18'h2A5F6,1'b0,4'd4},  // R4 gated strobe
    '{1'b1,1'b0,1'b0,1'b0,1'b0,18'h10003,18'h10003,1'b1,4'd9},  // R3 + R9
    '{1'b0,1'b1,1'b1,1'b0,1'b1,18'h3FFFF,18'h10003,1'b1,4'd10}, // R10 sleep
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h10000,1'b0,4'd6},  // R6 3+1
    '{1'b0,1'b1,1'b1,1'b0,1'b0,18'h3FFFC,18'h3FFFC,1'b1,4'd9},  // R9 ungated + adv
    '{1'b0,1'b0,1'b0,1'b1,1'b0,18'h00001,18'h00001,1'b1,4'd11}, // R11 back-to-back
    '{1'b1,1'b1,1'b1,1'b0,1'b0,18'h00000,18'h00002,1'b0,4'd11}  // R11 flag drops
  };

  task automatic check(input string tag, input logic [17:0] a_exp, input logic ld_exp);
    checks++;
    if (addr_out !== a_exp || load_seen !== ld_exp) begin
      failures++;
      $display("FAIL %s: addr_out=%h load_seen=%b expected addr_out=%h load_seen=%b",
               tag, addr_out, load_seen, a_exp, ld_exp);
    end
  endtask

  task automatic step(input logic c, input logic p, input logic e, input logic a,
                      input logic s, input logic [17:0] d);
    sa_ctl_n = c; sa_cpu_n = p; chip_en_n = e; adv_n = a; sleep = s; addr_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sa_ctl_n = 1'b1; sa_cpu_n = 1'b1; chip_en_n = 1'b1;
    adv_n = 1'b1; burst_order = 1'b0; sleep = 1'b0; addr_in = 18'h3FFFF;
    repeat (3) @(negedge clk);
    check("R1 reset state", 18'h00000, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      step(VECS[i].ctl_n, VECS[i].cpu_n, VECS[i].ce_n, VECS[i].adv_n,
           VECS[i].slp, VECS[i].din);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_a, VECS[i].exp_ld);
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 18'h00000, 1'b0);
    burst_order = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    // R7: interleaved from start 3
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h15557);
    check("R7 load", 18'h15557, 1'b1);
    @(negedge clk); step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0);
    check("R7 3^1", 18'h15556, 1'b0);
    @(negedge clk); step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0);
    check("R7 3^2", 18'h15555, 1'b0);
    @(negedge clk); step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0);
    check("R7 3^3", 18'h15554, 1'b0);
    @(negedge clk); step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0);
    check("R7 wrap R8", 18'h15557, 1'b0);
    @(negedge clk); step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00000);
    check("R4 R5 hold interleaved", 18'h15557, 1'b0);

    finish_run();
  end
endmodule